// File: doc/BRIEF.md
# Status-coded I2C master register controller

This block is the register front end of an I2C master. A host reads and writes byte-wide registers at word-spaced offsets. Each register access that moves a transaction forward is turned into one operation on an abstract byte-level bus port, in the same clock cycle. The four operations are: send an address with a direction bit, send a data byte, fetch a data byte, and end the transfer. The bit-level SCL/SDA engine is not part of this block.

The controller reports its progress as a 5-bit code held in bits 7:3 of the status register. It raises a level interrupt when a step completes. The host clears that interrupt through the control register, using a clear polarity chosen by a configuration pin. Reading the status or data register while a receive is pending moves the sequence on. A software-reset bit holds the controller inactive. Releasing that bit returns every register to its default.

Top module: `i2c_status_master`

## Requirements
- R1: After reset, status reads 0xF8 (idle code 0x1F), line control reads 0x3A, and every other mapped register reads 0. Register offsets: address 0x00, extended address 0x04, data 0x08, control 0x0C, status 0x10, clock 0x14, soft reset 0x18, feature 0x1C, line control 0x20. A read returns its value on `reg_rdata` one cycle after `reg_rd`.
- R2: Writes are masked. Clock keeps bits 6:0, feature keeps bits 1:0, line control keeps bits 5:0, address and extended address keep all 8 bits. Reads of unmapped offsets return 0.
- R3: Control bits are: 7 interrupt enable, 6 bus enable, 5 start, 4 stop, 3 flag, 2 assert-ACK. A control write with bit 5 set moves the status to 0x08 if it was idle, or to 0x10 otherwise. The start bit always reads back as 0.
- R4: A control write with bit 4 set pulses `bus_stop` and returns the status to 0xF8. The stop bit reads back as 0. If bits 4 and 5 are written together, the result is idle.
- R5: A data write in status 0x08 or 0x10 pulses `bus_start` with address = byte[7:1] and read flag = byte[0]. On NACK the status becomes 0x20 and the flag is not set. On ACK the status becomes 0x40 for a read or 0x18 for a write.
- R6: A data write in status 0x18 or 0x28 pulses `bus_send` with that byte. On ACK the status becomes 0x28. On NACK the status becomes 0x30, `bus_stop` pulses in the same cycle, and the flag is not set.
- R7: A data read in status 0x40, 0x50 or 0x58 pulses `bus_recv` and returns the fetched byte. The status then becomes 0x50 if assert-ACK is 1, or 0x58 if it is 0.
- R8: A status read in status 0x40 returns 0x40 and causes no bus operation. Afterwards the status becomes 0x50 or 0x58 by the assert-ACK rule.
- R9: A control write that clears assert-ACK turns status 0x50 into 0x58. One that sets assert-ACK turns 0x58 into 0x50.
- R10: The flag (control bit 3) is set whenever the status changes as described in R3, R5 (ACK), R6 (ACK), R7, R8 or R9, provided soft reset is 0, the bus is enabled and the new status is not idle. `irq` is high exactly when the flag and interrupt enable are both 1.
- R11: With `clr_inv` = 0, writing 0 to control bit 3 clears the flag and writing 1 leaves it unchanged. With `clr_inv` = 1, writing 1 clears the flag and writing 0 leaves it unchanged.
- R12: While soft reset is 1 or the bus is disabled, a data write causes no bus operation and leaves the data register unchanged. While soft reset is 1, control writes are ignored.
- R13: Writing 0 to soft-reset bit 0 while it holds 1 restores every register to its R1 value. If the status was not idle, `bus_stop` pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr_inv | input | 1 | Flag clear polarity: 0 means write 0 to clear, 1 means write 1 to clear |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | AW | Byte offset of the register |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, valid one cycle after `reg_rd` |
| irq | output | 1 | Level interrupt |
| bus_start | output | 1 | Pulse: send an address |
| bus_send | output | 1 | Pulse: send a data byte |
| bus_recv | output | 1 | Pulse: fetch a data byte |
| bus_stop | output | 1 | Pulse: end the transfer |
| bus_addr | output | 7 | Target address that goes with `bus_start` |
| bus_rd | output | 1 | Read flag that goes with `bus_start` |
| bus_tx_byte | output | 8 | Byte that goes with `bus_send` |
| bus_nack | input | 1 | Same-cycle reply to start or send: 1 means NACK |
| bus_rx_byte | input | 8 | Same-cycle byte returned for `bus_recv` |

## Verification
The assertions assume three things about the inputs. `reg_rd` and `reg_wr` are never high in the same cycle. The bus target answers `bus_nack` and `bus_rx_byte` combinationally, in the same cycle as the request pulse. `reg_addr` changes only on clock boundaries. The bench drives each access for exactly one cycle from the falling edge, with an idle cycle between accesses. Its target model is a pair of combinational assignments from bench variables that change only between accesses. These variables set the NACK reply and the byte returned.

// File: rtl/i2c_status_master.sv
module i2c_status_master #(
  parameter int AW = 6,
  parameter logic [5:0] LINE_INIT = 6'h3A
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_inv,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [AW-1:0] reg_addr,
  input  logic [7:0]    reg_wdata,
  output logic [7:0]    reg_rdata,
  output logic          irq,
  output logic          bus_start,
  output logic          bus_send,
  output logic          bus_recv,
  output logic          bus_stop,
  output logic [6:0]    bus_addr,
  output logic          bus_rd,
  output logic [7:0]    bus_tx_byte,
  input  logic          bus_nack,
  input  logic [7:0]    bus_rx_byte
);
  localparam logic [AW-1:0] O_ADR = AW'(6'h00), O_XADR = AW'(6'h04), O_DAT = AW'(6'h08),
                            O_CTL = AW'(6'h0C), O_STA = AW'(6'h10), O_CLK = AW'(6'h14),
                            O_RST = AW'(6'h18), O_FEA = AW'(6'h1C), O_LIN = AW'(6'h20);
  localparam logic [4:0] S_START = 5'd1, S_RSTART = 5'd2, S_AW_ACK = 5'd3, S_AW_NACK = 5'd4,
                         S_TX_ACK = 5'd5, S_TX_NACK = 5'd6, S_AR_ACK = 5'd8,
                         S_RX_ACK = 5'd10, S_RX_NACK = 5'd11, S_IDLE = 5'h1F;

  logic [4:0] st, st_n;
  logic [7:0] adr_q, xadr_q, dat_q;
  logic [6:0] clk_q;
  logic [1:0] fea_q;
  logic [5:0] lin_q;
  logic       srst_q, ien, ben, ack_en, flag;
  logic       raise, flag_n, flag_set;

  wire wr_dat = reg_wr && reg_addr == O_DAT;
  wire wr_ctl = reg_wr && reg_addr == O_CTL;
  wire wr_rst = reg_wr && reg_addr == O_RST;
  wire rd_dat = reg_rd && reg_addr == O_DAT;
  wire rd_sta = reg_rd && reg_addr == O_STA;

  wire dat_go   = wr_dat && !srst_q && ben;
  wire ctl_go   = wr_ctl && !srst_q;
  wire srst_rel = wr_rst && srst_q && !reg_wdata[0];
  wire ben_eff  = ctl_go ? reg_wdata[6] : ben;

  assign bus_start   = dat_go && (st == S_START || st == S_RSTART);
  assign bus_send    = dat_go && (st == S_AW_ACK || st == S_TX_ACK);
  assign bus_recv    = rd_dat && (st == S_AR_ACK || st == S_RX_ACK || st == S_RX_NACK);
  assign bus_stop    = (ctl_go && reg_wdata[4]) || (bus_send && bus_nack) ||
                       (srst_rel && st != S_IDLE);
  assign bus_addr    = reg_wdata[7:1];
  assign bus_rd      = reg_wdata[0];
  assign bus_tx_byte = reg_wdata;
  assign irq         = flag && ien;

  always_comb begin
    st_n  = st;
    raise = 1'b0;
    if (bus_start) begin
      if (bus_nack) st_n = S_AW_NACK;
      else begin st_n = reg_wdata[0] ? S_AR_ACK : S_AW_ACK; raise = 1'b1; end
    end else if (bus_send) begin
      if (bus_nack) st_n = S_TX_NACK;
      else begin st_n = S_TX_ACK; raise = 1'b1; end
    end else if (bus_recv || (rd_sta && st == S_AR_ACK)) begin
      st_n  = ack_en ? S_RX_ACK : S_RX_NACK;
      raise = 1'b1;
    end else if (ctl_go) begin
      if (reg_wdata[5]) begin
        st_n  = (st == S_IDLE) ? S_START : S_RSTART;
        raise = 1'b1;
      end
      if (reg_wdata[4]) begin
        st_n  = S_IDLE;
        raise = 1'b0;
      end
      if (!reg_wdata[2] && st_n == S_RX_ACK) begin
        st_n = S_RX_NACK; raise = 1'b1;
      end else if (reg_wdata[2] && st_n == S_RX_NACK) begin
        st_n = S_RX_ACK; raise = 1'b1;
      end
    end
  end

  assign flag_set = raise && !srst_q && ben_eff && st_n != S_IDLE;

  always_comb begin
    flag_n = flag;
    if (ctl_go && (reg_wdata[3] == clr_inv)) flag_n = 1'b0;
    if (flag_set) flag_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; adr_q <= '0; xadr_q <= '0; dat_q <= '0; clk_q <= '0;
      fea_q <= '0; lin_q <= LINE_INIT; srst_q <= 1'b0;
      ien <= 1'b0; ben <= 1'b0; ack_en <= 1'b0; flag <= 1'b0;
    end else if (srst_rel) begin
      st <= S_IDLE; adr_q <= '0; xadr_q <= '0; dat_q <= '0; clk_q <= '0;
      fea_q <= '0; lin_q <= LINE_INIT; srst_q <= 1'b0;
      ien <= 1'b0; ben <= 1'b0; ack_en <= 1'b0; flag <= 1'b0;
    end else begin
      st   <= st_n;
      flag <= flag_n;
      if (dat_go)   dat_q <= reg_wdata;
      if (bus_recv) dat_q <= bus_rx_byte;
      if (ctl_go) begin
        ien    <= reg_wdata[7];
        ben    <= reg_wdata[6];
        ack_en <= reg_wdata[2];
      end
      if (reg_wr) begin
        case (reg_addr)
          O_ADR:  adr_q  <= reg_wdata;
          O_XADR: xadr_q <= reg_wdata;
          O_CLK:  clk_q  <= reg_wdata[6:0];
          O_RST:  srst_q <= reg_wdata[0];
          O_FEA:  fea_q  <= reg_wdata[1:0];
          O_LIN:  lin_q  <= reg_wdata[5:0];
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) reg_rdata <= '0;
    else if (reg_rd) begin
      case (reg_addr)
        O_ADR:  reg_rdata <= adr_q;
        O_XADR: reg_rdata <= xadr_q;
        O_DAT:  reg_rdata <= bus_recv ? bus_rx_byte : dat_q;
        O_CTL:  reg_rdata <= {ien, ben, 2'b00, flag, ack_en, 2'b00};
        O_STA:  reg_rdata <= {st, 3'b000};
        O_CLK:  reg_rdata <= {1'b0, clk_q};
        O_RST:  reg_rdata <= {7'd0, srst_q};
        O_FEA:  reg_rdata <= {6'd0, fea_q};
        O_LIN:  reg_rdata <= {2'b00, lin_q};
        default: reg_rdata <= '0;
      endcase
    end
  end

  a_r3_start_code: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_go && reg_wdata[5] && !reg_wdata[4]) |=> (st == S_START || st == S_RSTART));
  a_r5_addr_result: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_start && !bus_nack) |=> (st == S_AW_ACK || st == S_AR_ACK));
  a_r6_tx_nack: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_send && bus_nack) |=> (st == S_TX_NACK && $stable(flag)));
  a_r8_status_poll: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_sta && st == S_AR_ACK) |=> ((st == S_RX_ACK || st == S_RX_NACK) && reg_rdata == 8'h40));
  a_r10_flag_busy: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> st != S_IDLE);
  a_r12_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_dat && (srst_q || !ben)) |=> $stable(dat_q));
  a_r13_release: assert property (@(posedge clk) disable iff (!rst_n)
    srst_rel |=> (st == S_IDLE && !ben && !ien && !flag && lin_q == LINE_INIT && clk_q == '0));
  a_r4_one_op: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({bus_start, bus_send, bus_recv}));
endmodule

// File: tb/sim_i2c_status_master.sv
module sim_i2c_status_master;
  logic clk = 1'b0, rst_n = 1'b0, clr_inv = 1'b0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [5:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic irq, bus_start, bus_send, bus_recv, bus_stop, bus_rd;
  logic [6:0] bus_addr;
  logic [7:0] bus_tx_byte;
  logic nack_cfg = 1'b0;
  logic [7:0] rx_cfg = 8'h00;
  wire bus_nack = nack_cfg;
  wire [7:0] bus_rx_byte = rx_cfg;

  always #10 clk = ~clk;

  i2c_status_master u0 (.clk(clk), .rst_n(rst_n), .clr_inv(clr_inv), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq(irq), .bus_start(bus_start), .bus_send(bus_send), .bus_recv(bus_recv),
    .bus_stop(bus_stop), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_tx_byte(bus_tx_byte),
    .bus_nack(bus_nack), .bus_rx_byte(bus_rx_byte));

  int total = 0, failed = 0;
  int n_start = 0, n_send = 0, n_recv = 0, n_stop = 0;
  logic [6:0] last_addr = '0;
  logic last_rd = 1'b0;
  logic [7:0] last_tx = '0;
  logic rd_q = 1'b0;
  logic [7:0] q_exp[$];
  string q_req[$];

  always @(posedge clk) begin
    rd_q <= reg_rd;
    if (bus_start) begin n_start <= n_start + 1; last_addr <= bus_addr; last_rd <= bus_rd; end
    if (bus_send) begin n_send <= n_send + 1; last_tx <= bus_tx_byte; end
    if (bus_recv) n_recv <= n_recv + 1;
    if (bus_stop) n_stop <= n_stop + 1;
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rd_q) begin
      if (q_exp.size() == 0) chk("scoreboard-empty", 1, 0);
      else chk(q_req.pop_front(), int'(reg_rdata), int'(q_exp.pop_front()));
    end
  end

  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, input logic [7:0] exp, input string req);
    q_exp.push_back(exp); q_req.push_back(req);
    @(negedge clk); reg_addr = a; reg_rd = 1'b1;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic report;
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  endtask

  initial begin
    #(20 * 100000);
    failed++; total++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    int s;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 defaults
    rd(6'h10, 8'hF8, "R1 status"); rd(6'h20, 8'h3A, "R1 line");
    rd(6'h0C, 8'h00, "R1 control"); rd(6'h08, 8'h00, "R1 data");
    chk("R1 irq", irq, 0);
    // R2 masks
    wr(6'h14, 8'hFF); rd(6'h14, 8'h7F, "R2 clock mask");
    wr(6'h1C, 8'hFF); rd(6'h1C, 8'h03, "R2 feature mask");
    wr(6'h20, 8'hFF); rd(6'h20, 8'h3F, "R2 line mask");
    wr(6'h00, 8'h9C); rd(6'h00, 8'h9C, "R2 address");
    wr(6'h04, 8'h5E); rd(6'h04, 8'h5E, "R2 ext address");
    wr(6'h24, 8'h77); rd(6'h24, 8'h00, "R2 unmapped");
    // enable, ack on
    wr(6'h0C, 8'hC4); rd(6'h0C, 8'hC4, "R3 control plain");
    // R3 start from idle
    wr(6'h0C, 8'hE4);
    rd(6'h10, 8'h08, "R3 start code"); rd(6'h0C, 8'hCC, "R3 start bit clear, R10 flag");
    chk("R10 irq raised", irq, 1);
    // R11 normal polarity
    wr(6'h0C, 8'hC4); chk("R11 clear by 0", irq, 0);
    // R5 address write ack
    s = n_start; nack_cfg = 1'b0;
    wr(6'h08, 8'hA0);
    chk("R5 start pulse", n_start, s + 1); chk("R5 addr", last_addr, 7'h50); chk("R5 rd flag", last_rd, 0);
    rd(6'h10, 8'h18, "R5 write ack code"); rd(6'h0C, 8'hCC, "R10 flag after addr");
    wr(6'h0C, 8'hC4);
    wr(6'h0C, 8'hCC); rd(6'h0C, 8'hC4, "R11 writing 1 keeps clear flag");
    // R6 send ack then nack
    s = n_send;
    wr(6'h08, 8'h3C);
    chk("R6 send pulse", n_send, s + 1); chk("R6 tx byte", last_tx, 8'h3C);
    rd(6'h10, 8'h28, "R6 tx ack code");
    wr(6'h0C, 8'hC4);
    s = n_stop; nack_cfg = 1'b1;
    wr(6'h08, 8'h77);
    chk("R6 nack ends", n_stop, s + 1);
    rd(6'h10, 8'h30, "R6 tx nack code"); chk("R6 no irq on nack", irq, 0);
    s = n_send; wr(6'h08, 8'h11); chk("R6 no send after nack", n_send, s);
    // R3 repeated start, R5 read address
    nack_cfg = 1'b0;
    wr(6'h0C, 8'hE4); rd(6'h10, 8'h10, "R3 repeated start");
    wr(6'h08, 8'hA1); chk("R5 read flag", last_rd, 1);
    // R8 status poll
    s = n_recv;
    rd(6'h10, 8'h40, "R8 read ack old value"); rd(6'h10, 8'h50, "R8 moved to rx ack");
    chk("R8 no bus op", n_recv, s);
    // R7 receive
    rx_cfg = 8'h5A;
    rd(6'h08, 8'h5A, "R7 rx byte"); chk("R7 recv pulse", n_recv, s + 1);
    rd(6'h10, 8'h50, "R7 ack code");
    // R9 ack toggle
    wr(6'h0C, 8'hC0); rd(6'h10, 8'h58, "R9 ack off");
    rd(6'h0C, 8'hC8, "R10 flag on toggle");
    rx_cfg = 8'hB6;
    rd(6'h08, 8'hB6, "R7 rx second"); rd(6'h10, 8'h58, "R7 nack code");
    wr(6'h0C, 8'hC4); rd(6'h10, 8'h50, "R9 ack on");
    // R4 stop
    s = n_stop;
    wr(6'h0C, 8'hD4);
    chk("R4 stop pulse", n_stop, s + 1);
    rd(6'h10, 8'hF8, "R4 idle"); rd(6'h0C, 8'hC4, "R4 stop bit clear");
    // R5 address nack
    wr(6'h0C, 8'hE4); wr(6'h0C, 8'hC4);
    nack_cfg = 1'b1; wr(6'h08, 8'hA0); nack_cfg = 1'b0;
    rd(6'h10, 8'h20, "R5 addr nack code"); rd(6'h0C, 8'hC4, "R5 no flag on nack");
    wr(6'h0C, 8'hD4);
    // R11 inverted polarity
    clr_inv = 1'b1;
    wr(6'h0C, 8'hE4); wr(6'h0C, 8'hC4);
    rd(6'h0C, 8'hCC, "R11 inverted write 0 keeps");
    wr(6'h0C, 8'hCC); rd(6'h0C, 8'hC4, "R11 inverted write 1 clears");
    chk("R11 irq low", irq, 0);
    wr(6'h0C, 8'hD4); clr_inv = 1'b0;
    // R10 irq needs enable
    wr(6'h0C, 8'h60); rd(6'h0C, 8'h48, "R10 flag without enable");
    chk("R10 irq masked", irq, 0);
    // R12 bus disabled
    wr(6'h0C, 8'h10); wr(6'h0C, 8'h20);
    rd(6'h0C, 8'h00, "R10 no flag when disabled");
    s = n_start; wr(6'h08, 8'h12);
    chk("R12 no op when disabled", n_start, s);
    rd(6'h08, 8'hA0, "R12 data kept");
    // R13 soft reset
    wr(6'h18, 8'h01); rd(6'h18, 8'h01, "R13 srst set");
    wr(6'h0C, 8'hC4); rd(6'h0C, 8'h00, "R12 control ignored in srst");
    wr(6'h14, 8'h11);
    s = n_stop;
    wr(6'h18, 8'h00);
    chk("R13 stop on release", n_stop, s + 1);
    rd(6'h10, 8'hF8, "R13 status"); rd(6'h14, 8'h00, "R13 clock");
    rd(6'h20, 8'h3A, "R13 line"); rd(6'h00, 8'h00, "R13 address");
    rd(6'h18, 8'h00, "R13 srst");
    repeat (3) @(negedge clk);
    chk("scoreboard drained", q_exp.size(), 0);
    report();
  end
endmodule